// File: doc/BRIEF.md
# Streaming Multiprocessor Occupancy Calculator

This block works out how much of one streaming multiprocessor a kernel launch can fill. It takes the launch shape as inputs: threads per block and registers per thread. It also takes the multiprocessor's configured ceilings: warp slots, block slots, register-file size and the largest legal block. From these it finds the number of blocks that can be resident at once and the number of warps those blocks occupy. It reports which ceiling was binding and gives the occupied fraction of warp slots as an unsigned Q0.16 value.

Work begins with a single-cycle start pulse. The block copies every input at that edge. It then runs up to three divisions in sequence on one shared bit-serial divider. A single-cycle done pulse marks the result. The result stays on the outputs until a later run finishes. A start that arrives while a run is in progress is ignored. Illegal launches skip the divider and finish on the cycle after start.

Top module: `occ_calc`

## Requirements
- R1: Warps per block equal threads per block divided by 32, rounded up (for example 33 threads take 2 warps and 100 threads take 4).
- R2: A launch is rejected when threads per block is 0, when it exceeds the configured per-block maximum, or when the warp-slot ceiling is 0. A rejected launch reports `launch_bad`=1, zero blocks, zero warps, occupancy 0 and limit code 3, with done one cycle after start.
- R3: The register-limited block count is floor(register-file size / (registers per thread × 32 × warps per block)). Registers per thread of 0 removes the register limit.
- R4: Resident blocks are the smallest of three values: the block-slot ceiling, floor(warp-slot ceiling / warps per block) and the register-limited count.
- R5: Resident warps equal resident blocks × warps per block.
- R6: Occupancy equals floor(resident warps × 65536 / warp-slot ceiling). It saturates to 0xFFFF when every warp slot is filled, and it is 0 when no block fits.
- R7: `limit_code` is 0 when the register file binds, 1 when warp slots bind and 2 when block slots bind. When values are equal the first of the order registers, warps, blocks wins. Code 3 marks a rejected launch.
- R8: A start seen while idle raises `busy` on the next cycle for a legal launch. `done` is a single-cycle pulse with `busy` low. A start seen while busy is ignored.
- R9: Result outputs change only on the cycle `done` is high. Between runs they hold, whatever the inputs do.
- R10: After reset `busy`, `done`, `launch_bad`, `res_blocks`, `res_warps`, `limit_code` and `occupancy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle launch request, sampled when idle |
| thr_per_blk | input | TPB_W (11) | Threads in one block |
| regs_per_thr | input | RPT_W (8) | Registers each thread needs |
| max_warps | input | WARP_W (7) | Warp-slot ceiling of the multiprocessor |
| max_blocks | input | BLK_W (6) | Block-slot ceiling |
| rf_size | input | RF_W (17) | Registers in the register file |
| max_thr_blk | input | TPB_W (11) | Largest legal block in threads |
| busy | output | 1 | A calculation is running |
| done | output | 1 | Single-cycle pulse: results updated |
| launch_bad | output | 1 | Last launch was rejected |
| res_blocks | output | BLK_W (6) | Resident blocks |
| res_warps | output | WARP_W (7) | Resident warps |
| limit_code | output | 2 | Binding ceiling: 0 regs, 1 warps, 2 blocks, 3 rejected |
| occupancy | output | OCC_W (16) | Occupied fraction of warp slots, Q0.16 |

## Verification
A wrong quotient from the shared divider would not go unnoticed. A bad warp-limit or register-limit quotient shows up in `res_blocks` and `limit_code` at the very next done pulse. A bad final division shows up only in `occupancy`. A phase sequencer that loses its place shows either as `busy` stuck high, which the per-run timeout catches within a few hundred cycles, or as result ports that move without a done pulse. Sweeping thread counts across warp boundaries, register counts including zero, and two settings of each ceiling drives every tie and every binding ceiling, so a wrong comparison order changes `limit_code` on the first run that reaches that tie.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        LIM_REGS   = 2'd0,
        LIM_WARPS  = 2'd1,
        LIM_BLOCKS = 2'd2,
        LIM_NONE   = 2'd3
    } lim_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WDIV = 3'd1,
        PH_RDIV = 3'd2,
        PH_PICK = 3'd3,
        PH_ODIV = 3'd4
    } phase_e;

endpackage

// File: rtl/occ_iter_div.sv
// Restoring divider, one quotient bit per cycle; result W cycles after go.
module occ_iter_div #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          act;
        logic          fin;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  acc;
        logic [W-1:0]  dvs;
    } dstate_t;

    dstate_t q, d;
    logic [W:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        trial = {q.rem[W-1:0], q.acc[W-1]};
        if (go && !q.act) begin
            d.act = 1'b1;
            d.cnt = CW'(W - 1);
            d.rem = '0;
            d.acc = num;
            d.dvs = den;
        end else if (q.act) begin
            if (trial >= {1'b0, q.dvs}) begin
                d.rem = trial - {1'b0, q.dvs};
                d.acc = {q.acc[W-2:0], 1'b1};
            end else begin
                d.rem = trial;
                d.acc = {q.acc[W-2:0], 1'b0};
            end
            if (q.cnt == '0) begin
                d.act = 1'b0;
                d.fin = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.act;
    assign done = q.fin;
    assign quo  = q.acc;

    // R3 / R6: the sequencer never restarts a running division
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !q.act);
    // R3 / R6: a zero divisor never reaches the divider
    a_r6_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (den != '0));
    // R6: a partial remainder stays below the divisor
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.act |-> (q.rem < {1'b0, q.dvs}));
    // R8: completion drops the busy flag in the same cycle
    a_r8_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin |-> !q.act);

endmodule

// File: rtl/occ_front.sv
// Launch shape: warps per block, registers per block, legality.
module occ_front #(
    parameter int TPB_W   = 11,
    parameter int RPT_W   = 8,
    parameter int WARP_W  = 7,
    parameter int LANE_SH = 5,
    parameter int WPB_W   = 7,
    parameter int RPB_W   = 20
) (
    input  logic [TPB_W-1:0]  thr,
    input  logic [RPT_W-1:0]  rpt,
    input  logic [TPB_W-1:0]  max_thr,
    input  logic [WARP_W-1:0] max_warps,
    output logic [WPB_W-1:0]  wpb,
    output logic [RPB_W-1:0]  rpb,
    output logic              regs_none,
    output logic              bad
);
    localparam int SUM_W = TPB_W + 1;
    localparam logic [SUM_W-1:0] ROUND = SUM_W'((1 << LANE_SH) - 1);

    logic [SUM_W-1:0] padded;

    always_comb begin
        padded    = {1'b0, thr} + ROUND;
        wpb       = WPB_W'(padded >> LANE_SH);
        rpb       = (RPB_W'(rpt) * RPB_W'(wpb)) << LANE_SH;
        regs_none = (rpt == '0);
        bad       = (thr == '0) || (thr > max_thr) || (max_warps == '0);
    end

endmodule

// File: rtl/occ_select.sv
// Minimum of the three ceilings with the tie order regs, warps, blocks.
module occ_select
    import occ_pkg::*;
#(
    parameter int W      = 23,
    parameter int BLK_W  = 6,
    parameter int WARP_W = 7,
    parameter int WPB_W  = 7
) (
    input  logic [W-1:0]      warp_lim,
    input  logic [W-1:0]      reg_lim,
    input  logic              regs_none,
    input  logic [BLK_W-1:0]  blk_cap,
    input  logic [WPB_W-1:0]  wpb,
    output logic [BLK_W-1:0]  blocks,
    output logic [WARP_W-1:0] warps,
    output lim_e              code
);
    logic [W-1:0] blk_w;
    logic [W-1:0] pick;
    logic [W-1:0] prod;

    always_comb begin
        blk_w = W'(blk_cap);
        if (!regs_none && (reg_lim <= warp_lim) && (reg_lim <= blk_w)) begin
            pick = reg_lim;
            code = LIM_REGS;
        end else if (warp_lim <= blk_w) begin
            pick = warp_lim;
            code = LIM_WARPS;
        end else begin
            pick = blk_w;
            code = LIM_BLOCKS;
        end
        prod   = pick * W'(wpb);
        blocks = BLK_W'(pick);
        warps  = WARP_W'(prod);
    end

endmodule

// File: rtl/occ_calc.sv
module occ_calc
    import occ_pkg::*;
#(
    parameter int TPB_W  = 11,
    parameter int RPT_W  = 8,
    parameter int WARP_W = 7,
    parameter int BLK_W  = 6,
    parameter int RF_W   = 17,
    parameter int OCC_W  = 16,
    parameter int LANES  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TPB_W-1:0]  thr_per_blk,
    input  logic [RPT_W-1:0]  regs_per_thr,
    input  logic [WARP_W-1:0] max_warps,
    input  logic [BLK_W-1:0]  max_blocks,
    input  logic [RF_W-1:0]   rf_size,
    input  logic [TPB_W-1:0]  max_thr_blk,
    output logic              busy,
    output logic              done,
    output logic              launch_bad,
    output logic [BLK_W-1:0]  res_blocks,
    output logic [WARP_W-1:0] res_warps,
    output logic [1:0]        limit_code,
    output logic [OCC_W-1:0]  occupancy
);
    localparam int LANE_SH = $clog2(LANES);
    localparam int WPB_W   = TPB_W + 1 - LANE_SH;
    localparam int RPB_W   = RPT_W + LANE_SH + WPB_W;
    localparam int DIV_A   = (RF_W > RPB_W) ? RF_W : RPB_W;
    localparam int DIV_W   = (DIV_A > WARP_W + OCC_W) ? DIV_A : WARP_W + OCC_W;

    typedef struct packed {
        phase_e            ph;
        logic [RF_W-1:0]   rf;
        logic [WARP_W-1:0] mw;
        logic [BLK_W-1:0]  mb;
        logic [WPB_W-1:0]  wpb;
        logic [RPB_W-1:0]  rpb;
        logic              rnone;
        logic [DIV_W-1:0]  wlim;
        logic [DIV_W-1:0]  rlim;
        logic [BLK_W-1:0]  pblk;
        logic [WARP_W-1:0] pwarp;
        lim_e              pcode;
        logic [BLK_W-1:0]  oblk;
        logic [WARP_W-1:0] owarp;
        lim_e              ocode;
        logic [OCC_W-1:0]  oocc;
        logic              obad;
        logic              done;
    } ctl_t;

    ctl_t q, d;

    logic [WPB_W-1:0]  f_wpb;
    logic [RPB_W-1:0]  f_rpb;
    logic              f_rnone;
    logic              f_bad;
    logic [BLK_W-1:0]  s_blk;
    logic [WARP_W-1:0] s_warp;
    lim_e              s_code;
    logic              div_go;
    logic [DIV_W-1:0]  div_num;
    logic [DIV_W-1:0]  div_den;
    logic              div_busy;
    logic              div_done;
    logic [DIV_W-1:0]  div_quo;

    occ_front #(
        .TPB_W  (TPB_W),
        .RPT_W  (RPT_W),
        .WARP_W (WARP_W),
        .LANE_SH(LANE_SH),
        .WPB_W  (WPB_W),
        .RPB_W  (RPB_W)
    ) u_front (
        .thr      (thr_per_blk),
        .rpt      (regs_per_thr),
        .max_thr  (max_thr_blk),
        .max_warps(max_warps),
        .wpb      (f_wpb),
        .rpb      (f_rpb),
        .regs_none(f_rnone),
        .bad      (f_bad)
    );

    occ_select #(
        .W     (DIV_W),
        .BLK_W (BLK_W),
        .WARP_W(WARP_W),
        .WPB_W (WPB_W)
    ) u_select (
        .warp_lim (q.wlim),
        .reg_lim  (q.rlim),
        .regs_none(q.rnone),
        .blk_cap  (q.mb),
        .wpb      (q.wpb),
        .blocks   (s_blk),
        .warps    (s_warp),
        .code     (s_code)
    );

    occ_iter_div #(
        .W(DIV_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quo  (div_quo)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.rf    = rf_size;
                    d.mw    = max_warps;
                    d.mb    = max_blocks;
                    d.wpb   = f_wpb;
                    d.rpb   = f_rpb;
                    d.rnone = f_rnone;
                    if (f_bad) begin
                        d.oblk  = '0;
                        d.owarp = '0;
                        d.ocode = LIM_NONE;
                        d.oocc  = '0;
                        d.obad  = 1'b1;
                        d.done  = 1'b1;
                    end else begin
                        div_go  = 1'b1;
                        div_num = DIV_W'(max_warps);
                        div_den = DIV_W'(f_wpb);
                        d.ph    = PH_WDIV;
                    end
                end
            end
            PH_WDIV: begin
                if (div_done) begin
                    d.wlim = div_quo;
                    if (q.rnone) begin
                        d.rlim = '1;
                        d.ph   = PH_PICK;
                    end else begin
                        div_go  = 1'b1;
                        div_num = DIV_W'(q.rf);
                        div_den = DIV_W'(q.rpb);
                        d.ph    = PH_RDIV;
                    end
                end
            end
            PH_RDIV: begin
                if (div_done) begin
                    d.rlim = div_quo;
                    d.ph   = PH_PICK;
                end
            end
            PH_PICK: begin
                d.pblk  = s_blk;
                d.pwarp = s_warp;
                d.pcode = s_code;
                if (s_warp == '0) begin
                    d.oblk  = s_blk;
                    d.owarp = '0;
                    d.ocode = s_code;
                    d.oocc  = '0;
                    d.obad  = 1'b0;
                    d.done  = 1'b1;
                    d.ph    = PH_IDLE;
                end else begin
                    div_go  = 1'b1;
                    div_num = DIV_W'({s_warp, OCC_W'(0)});
                    div_den = DIV_W'(q.mw);
                    d.ph    = PH_ODIV;
                end
            end
            PH_ODIV: begin
                if (div_done) begin
                    d.oblk  = q.pblk;
                    d.owarp = q.pwarp;
                    d.ocode = q.pcode;
                    d.oocc  = ((div_quo >> OCC_W) != '0) ? '1 : div_quo[OCC_W-1:0];
                    d.obad  = 1'b0;
                    d.done  = 1'b1;
                    d.ph    = PH_IDLE;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
            q.pcode <= LIM_REGS;
            q.ocode <= LIM_REGS;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.ph != PH_IDLE);
    assign done       = q.done;
    assign launch_bad = q.obad;
    assign res_blocks = q.oblk;
    assign res_warps  = q.owarp;
    assign limit_code = q.ocode;
    assign occupancy  = q.oocc;

    // R8: done lasts exactly one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: results are reported only once the sequencer is idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: result ports hold between done pulses
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_blocks) && $stable(res_warps)
                   && $stable(limit_code) && $stable(occupancy)));
    // R4: resident blocks never exceed the block-slot ceiling
    a_r4_blocks_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_blocks <= q.mb));
    // R5: resident warps never exceed the warp-slot ceiling
    a_r5_warps_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !launch_bad) |-> (res_warps <= q.mw));
    // R6: a full set of warp slots saturates the fraction
    a_r6_full_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !launch_bad && (res_warps == q.mw)) |-> (occupancy == '1));
    // R2 / R7: a rejected launch carries the reject code and no blocks
    a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && launch_bad) |-> ((limit_code == 2'd3) && (res_blocks == '0)));
    // R2: the divider is idle whenever the sequencer is idle
    a_r2_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !div_busy);

endmodule

// File: tb/sim_occ_calc.sv
`timescale 1ns/1ps
module sim_occ_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] thr_per_blk = '0;
    logic [7:0]  regs_per_thr = '0;
    logic [6:0]  max_warps = '0;
    logic [5:0]  max_blocks = '0;
    logic [16:0] rf_size = '0;
    logic [10:0] max_thr_blk = '0;
    logic        busy, done, launch_bad;
    logic [5:0]  res_blocks;
    logic [6:0]  res_warps;
    logic [1:0]  limit_code;
    logic [15:0] occupancy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    occ_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .thr_per_blk(thr_per_blk), .regs_per_thr(regs_per_thr),
        .max_warps(max_warps), .max_blocks(max_blocks),
        .rf_size(rf_size), .max_thr_blk(max_thr_blk),
        .busy(busy), .done(done), .launch_bad(launch_bad),
        .res_blocks(res_blocks), .res_warps(res_warps),
        .limit_code(limit_code), .occupancy(occupancy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result from the requirements
    int e_bad, e_blk, e_warp, e_code, e_occ;
    task automatic model(input int thr, input int rpt, input int mw,
                         input int mb, input int rf, input int mt);
        int wpb, wl, rl, pick;
        if (thr == 0 || thr > mt || mw == 0) begin
            e_bad = 1; e_blk = 0; e_warp = 0; e_code = 3; e_occ = 0;
            return;
        end
        e_bad = 0;
        wpb = (thr + 31) / 32;                    // R1
        wl  = mw / wpb;
        if (rpt != 0) rl = rf / (rpt * 32 * wpb); // R3
        else          rl = 0;
        if (rpt != 0 && rl <= wl && rl <= mb) begin pick = rl; e_code = 0; end
        else if (wl <= mb)                    begin pick = wl; e_code = 1; end
        else                                  begin pick = mb; e_code = 2; end
        e_blk  = pick;                            // R4
        e_warp = pick * wpb;                      // R5
        e_occ  = (e_warp * 65536) / mw;           // R6
        if (e_occ > 65535) e_occ = 65535;
    endtask

    task automatic drive(input int thr, input int rpt, input int mw,
                         input int mb, input int rf, input int mt);
        thr_per_blk  = 11'(thr);
        regs_per_thr = 8'(rpt);
        max_warps    = 7'(mw);
        max_blocks   = 6'(mb);
        rf_size      = 17'(rf);
        max_thr_blk  = 11'(mt);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (!done) check("R8 timeout", 0, 1);
    endtask

    task automatic check_outputs();
        check("R2 launch_bad", int'(launch_bad), e_bad);
        check("R4 res_blocks", int'(res_blocks), e_blk);
        check("R5 res_warps", int'(res_warps), e_warp);
        check("R7 limit_code", int'(limit_code), e_code);
        check("R6 occupancy", int'(occupancy), e_occ);
    endtask

    task automatic run_case(input int thr, input int rpt, input int mw,
                            input int mb, input int rf, input int mt);
        model(thr, rpt, mw, mb, rf, mt);
        @(negedge clk);
        drive(thr, rpt, mw, mb, rf, mt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (e_bad == 1) begin
            check("R2 done next cycle", int'(done), 1);
        end else begin
            check("R8 busy after start", int'(busy), 1);
            check("R8 no early done", int'(done), 0);
        end
        wait_done();
        check("R8 idle at done", int'(busy), 0);
        check_outputs();
        @(negedge clk);
        check("R8 done one cycle", int'(done), 0);
    endtask

    initial begin : watchdog
        while (cycles < 190000 && !finished) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    int thr_set[15] = '{1, 31, 32, 33, 64, 100, 128, 256, 257, 512, 768, 1000, 1024, 1025, 0};
    int rpt_set[6]  = '{0, 16, 32, 40, 64, 255};

    initial begin : stim
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 launch_bad", int'(launch_bad), 0);
        check("R10 res_blocks", int'(res_blocks), 0);
        check("R10 res_warps", int'(res_warps), 0);
        check("R10 limit_code", int'(limit_code), 0);
        check("R10 occupancy", int'(occupancy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Point cases
        run_case(256, 32, 64, 16, 65536, 1024);  // R3 regs bind: 8 blocks? 65536/8192=8, warps 64 -> full
        run_case(100, 0, 64, 16, 65536, 1024);   // R1 4 warps, R4 tie regs off warps=16 blocks=16 -> warps
        run_case(600, 8, 64, 16, 65536, 512);    // R2 above per-block maximum
        run_case(32, 8, 0, 16, 65536, 1024);     // R2 zero warp ceiling
        run_case(1024, 255, 64, 16, 65536, 1024);// R6 no block fits, occupancy 0

        // Sweep over ceilings, thread counts and register counts
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 2; c++)
                    for (int t = 0; t < 15; t++)
                        for (int r = 0; r < 6; r++)
                            run_case(thr_set[t], rpt_set[r], a ? 48 : 64,
                                     b ? 8 : 16, c ? 32768 : 65536, 1024);

        // R8: start while busy is ignored
        model(128, 32, 64, 16, 65536, 1024);
        @(negedge clk);
        drive(128, 32, 64, 16, 65536, 1024);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        drive(32, 0, 48, 4, 1000, 1024);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R8 ignored start blocks", int'(res_blocks), e_blk);
        check("R8 ignored start occupancy", int'(occupancy), e_occ);
        check("R8 ignored start code", int'(limit_code), e_code);
        @(negedge clk);
        check("R8 no second done", int'(busy), 0);

        // R9: outputs hold without a start while inputs change
        drive(1000, 64, 20, 2, 4096, 1024);
        repeat (10) begin
            @(negedge clk);
            check("R9 hold done low", int'(done), 0);
        end
        check("R9 hold blocks", int'(res_blocks), e_blk);
        check("R9 hold warps", int'(res_warps), e_warp);
        check("R9 hold occupancy", int'(occupancy), e_occ);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule